// File: doc/BRIEF.md
# GPIO pad configuration lock bank

This block holds the software-visible settings for one group of general-purpose I/O pads: a per-pad configuration word, a bank-wide non-maskable-interrupt enable vector, a host-software ownership vector, an owner vector and a lock vector. Software reaches it through a simple synchronous register port. Each access is one cycle long with `bus_en` high. `bus_we` selects a write. Read data appears on `bus_rdata` in the cycle after the read and holds until the next read. The resolved pad settings are driven out continuously so that pad logic elsewhere can use them.

A pad becomes protected when its lock bit is set and its owner bit says the host owns it. A write to a protected pad's direction/buffer pair or mode field is dropped without any indication. The same applies to its interrupt enable bit and its ownership bit. The transmit-state bit stays writable. A pad owned by another agent ignores its lock bit. Reads always return the stored values, whether or not the pad is locked.

The register port has no back-pressure. Each access completes in the cycle it is presented, so a new access may follow on every cycle.

Top module: `gpio_lock_bank`

## Requirements
- R1: After reset, every register reads zero and every pad output is zero.
- R2: The lock register at 0x00 keeps one writable lock bit per pad in bits NUM_PADS-1:0, with bit n for pad n. Its bits 31:NUM_PADS read zero and ignore writes.
- R3: When lock bit n is 1 and owner bit n is 1 (owner register at 0x04, 1 = host), a write to pad n's configuration register at 0x10+4*n leaves the direction/buffer pair (bits 9:8) and the mode field (bits 12:10) unchanged.
- R4: The transmit-state bit (bit 0 of a configuration register) takes the written value on every write, locked or not. A single write that changes both protected bits and bit 0 of a protected pad updates only bit 0.
- R5: For a protected pad n, writes to the interrupt enable register (0x08) and the host-software ownership register (0x0C) leave bit n unchanged, while unprotected bits in the same write take the new value.
- R6: A pad whose owner bit is 0 accepts all writes even when its lock bit is 1.
- R7: A read returns the register's stored value in the cycle after the access. Bit 1 of a configuration register returns the pad input sampled one cycle earlier and ignores writes.
- R8: Configuration bits other than 0, 1 and 12:8 read zero. A write to an undefined address, including any address with bits 1:0 not zero, changes no register, and a read of such an address returns zero.
- R9: pad_tx_o, pad_dirbuf_o, pad_mode_o, nmi_en_o and swown_o drive the stored fields of every pad. Pad n occupies bit n, bits 2n+1:2n and bits 3n+2:3n respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_rx_i | input | NUM_PADS | Receive level from each pad |
| pad_tx_o | output | NUM_PADS | Transmit state per pad |
| pad_dirbuf_o | output | 2*NUM_PADS | Direction/buffer pair per pad |
| pad_mode_o | output | 3*NUM_PADS | Mode field per pad |
| nmi_en_o | output | NUM_PADS | Interrupt enable per pad |
| swown_o | output | NUM_PADS | Host-software ownership per pad |

## Verification
The bench builds the block with its defaults: NUM_PADS = 24 and ADDR_W = 8. With 24 pads, the lock register has eight reserved high bits, so writing all ones shows that they stay zero. With an 8-bit address, the last configuration register at 0x6C and the first undefined address at 0x70 are both reachable. Owner and lock patterns put a locked host pad, an unlocked host pad and a locked non-host pad side by side, so the same write can be blocked on one pad and accepted on its neighbours.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned TX_BIT   = 0;
  localparam int unsigned RX_BIT   = 1;
  localparam int unsigned DB_LSB   = 8;
  localparam int unsigned MODE_LSB = 10;

  localparam int unsigned OFS_LOCK  = 'h00;
  localparam int unsigned OFS_OWNER = 'h04;
  localparam int unsigned OFS_NMI   = 'h08;
  localparam int unsigned OFS_SWOWN = 'h0C;
  localparam int unsigned OFS_CFG   = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LOCK, SEL_OWNER, SEL_NMI, SEL_SWOWN, SEL_CFG
  } sel_e;

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] dirbuf;
    logic       tx;
  } pad_cfg_t;
endpackage

// File: rtl/gpl_decode.sv
module gpl_decode
  import gpl_pkg::*;
#(
  parameter int unsigned NUM_PADS = 24,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(OFS_CFG + 4 * NUM_PADS);

  logic [ADDR_W-1:0] cfg_off;
  assign cfg_off = addr - CFG_LO;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == ADDR_W'(OFS_LOCK))       sel = SEL_LOCK;
      else if (addr == ADDR_W'(OFS_OWNER)) sel = SEL_OWNER;
      else if (addr == ADDR_W'(OFS_NMI))   sel = SEL_NMI;
      else if (addr == ADDR_W'(OFS_SWOWN)) sel = SEL_SWOWN;
      else if (addr >= CFG_LO && addr < CFG_HI) begin
        sel = SEL_CFG;
        idx = IDX_W'(cfg_off >> 2);
      end
    end
  end
endmodule

// File: rtl/gpl_mask_reg.sv
module gpl_mask_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] keep,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= (q & keep) | (wdata & ~keep);
  end

  // R5
  keep_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q ^ $past(q)) & $past(keep)) == '0);

  // R6
  open_bits_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q ^ $past(wdata)) & ~$past(keep)) == '0);
endmodule

// File: rtl/gpl_pad_cell.sv
module gpl_pad_cell
  import gpl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pad_cfg_t wr_cfg,
  input  logic     prot,
  input  logic     pad_rx,
  output pad_cfg_t cfg_q,
  output logic     rx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rx_q  <= 1'b0;
    end else begin
      rx_q <= pad_rx;
      if (wr_en) begin
        cfg_q.tx <= wr_cfg.tx;
        if (!prot) begin
          cfg_q.dirbuf <= wr_cfg.dirbuf;
          cfg_q.mode   <= wr_cfg.mode;
        end
      end
    end
  end

  // R3
  locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot) |=> (cfg_q.mode == $past(cfg_q.mode)) && (cfg_q.dirbuf == $past(cfg_q.dirbuf)));

  // R4
  tx_always_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q.tx == $past(wr_cfg.tx));

  // R6
  open_cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !prot) |=> (cfg_q.mode == $past(wr_cfg.mode)) && (cfg_q.dirbuf == $past(wr_cfg.dirbuf)));
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
  import gpl_pkg::*;
#(
  parameter int unsigned NUM_PADS = 24,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PADS-1:0]   pad_rx_i,
  output logic [NUM_PADS-1:0]   pad_tx_o,
  output logic [2*NUM_PADS-1:0] pad_dirbuf_o,
  output logic [3*NUM_PADS-1:0] pad_mode_o,
  output logic [NUM_PADS-1:0]   nmi_en_o,
  output logic [NUM_PADS-1:0]   swown_o
);
  localparam int unsigned IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  sel_e               sel;
  logic [IDX_W-1:0]   idx;
  logic               wr, rd;
  logic [NUM_PADS-1:0] lock_q, owner_q, nmi_q, swown_q, prot, rx_arr;
  pad_cfg_t           cfg_arr [NUM_PADS];
  pad_cfg_t           wr_cfg;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wbits;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;
  assign prot = lock_q & owner_q;
  assign unused_wbits = ^bus_wdata;
  assign wr_cfg = '{mode: bus_wdata[MODE_LSB +: 3], dirbuf: bus_wdata[DB_LSB +: 2], tx: bus_wdata[TX_BIT]};

  gpl_decode #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr(bus_addr), .sel(sel), .idx(idx)
  );

  gpl_mask_reg #(.W(NUM_PADS)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && sel == SEL_LOCK),
    .wdata(bus_wdata[NUM_PADS-1:0]), .keep('0), .q(lock_q)
  );
  gpl_mask_reg #(.W(NUM_PADS)) u_owner (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && sel == SEL_OWNER),
    .wdata(bus_wdata[NUM_PADS-1:0]), .keep('0), .q(owner_q)
  );
  gpl_mask_reg #(.W(NUM_PADS)) u_nmi (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && sel == SEL_NMI),
    .wdata(bus_wdata[NUM_PADS-1:0]), .keep(prot), .q(nmi_q)
  );
  gpl_mask_reg #(.W(NUM_PADS)) u_swown (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && sel == SEL_SWOWN),
    .wdata(bus_wdata[NUM_PADS-1:0]), .keep(prot), .q(swown_q)
  );

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    gpl_pad_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr && sel == SEL_CFG && idx == IDX_W'(g)),
      .wr_cfg(wr_cfg), .prot(prot[g]), .pad_rx(pad_rx_i[g]),
      .cfg_q(cfg_arr[g]), .rx_q(rx_arr[g])
    );
    assign pad_tx_o[g]          = cfg_arr[g].tx;
    assign pad_dirbuf_o[2*g +: 2] = cfg_arr[g].dirbuf;
    assign pad_mode_o[3*g +: 3]   = cfg_arr[g].mode;
  end

  assign nmi_en_o = nmi_q;
  assign swown_o  = swown_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_LOCK:  rd_mux = DATA_W'(lock_q);
      SEL_OWNER: rd_mux = DATA_W'(owner_q);
      SEL_NMI:   rd_mux = DATA_W'(nmi_q);
      SEL_SWOWN: rd_mux = DATA_W'(swown_q);
      SEL_CFG: begin
        rd_mux[TX_BIT]          = cfg_arr[idx].tx;
        rd_mux[RX_BIT]          = rx_arr[idx];
        rd_mux[DB_LSB +: 2]     = cfg_arr[idx].dirbuf;
        rd_mux[MODE_LSB +: 3]   = cfg_arr[idx].mode;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R2
  lock_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_LOCK) |=> (bus_rdata >> NUM_PADS) == '0);

  // R8
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> bus_rdata == '0);

  // R8
  cfg_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_CFG) |=> (bus_rdata & 32'hFFFF_E0FC) == '0);

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_lock_bank_bench.sv
`timescale 1ns/1ps
module gpio_lock_bank_bench;
  localparam int unsigned NP = 24;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_rx_i = '0;
  logic [NP-1:0] pad_tx_o, nmi_en_o, swown_o;
  logic [2*NP-1:0] pad_dirbuf_o;
  logic [3*NP-1:0] pad_mode_o;

  int total = 0, fails = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  gpio_lock_bank #(.NUM_PADS(NP), .ADDR_W(AW)) u_gpio_lock_bank (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_rx_i(pad_rx_i), .pad_tx_o(pad_tx_o), .pad_dirbuf_o(pad_dirbuf_o),
    .pad_mode_o(pad_mode_o), .nmi_en_o(nmi_en_o), .swown_o(swown_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rst_n & bus_en & ~bus_we;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 outputs", {pad_tx_o, nmi_en_o, swown_o, 8'h0}, 32'h0);
    check("R1 mode out", 32'(pad_mode_o[31:0]), 32'h0);
    rd(8'h00, 32'h0, "R1 lock");
    rd(8'h04, 32'h0, "R1 owner");
    rd(8'h08, 32'h0, "R1 nmi");
    rd(8'h10, 32'h0, "R1 cfg0");
    // R2 reserved lock bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h00FF_FFFF, "R2 lock rsvd");
    // setup while unlocked: pads 0,1 host
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0000_0003);
    wr(8'h10, 32'h0000_1600);
    wr(8'h08, 32'h0000_0001);
    wr(8'h0C, 32'h0000_0001);
    wr(8'h00, 32'h0000_0005);
    rd(8'h00, 32'h0000_0005, "R2 lock bits");
    // R3 R4 combined write to locked host pad
    wr(8'h10, 32'h0000_1D01);
    rd(8'h10, 32'h0000_1601, "R3 R4 locked cfg0");
    check("R4 tx out", 32'(pad_tx_o[0]), 32'h1);
    wr(8'h10, 32'h0000_1600);
    rd(8'h10, 32'h0000_1600, "R4 tx toggle");
    // R8 reserved cfg bits, R7 rx bit
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h0000_1F01, "R8 cfg rsvd");
    pad_rx_i[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h14, 32'h0000_1F03, "R7 rx sample");
    wr(8'h14, 32'h0000_0000);
    rd(8'h14, 32'h0000_0002, "R7 rx not writable");
    // R5 nmi and swown under lock
    wr(8'h08, 32'h0000_0006);
    rd(8'h08, 32'h0000_0007, "R5 nmi");
    wr(8'h0C, 32'h0000_0000);
    rd(8'h0C, 32'h0000_0001, "R5 swown");
    // R6 locked non-host pad accepts writes
    wr(8'h18, 32'h0000_0C00);
    rd(8'h18, 32'h0000_0C00, "R6 cfg2");
    // last cfg and undefined addresses
    wr(8'h6C, 32'h0000_1C00);
    rd(8'h6C, 32'h0000_1C00, "R8 cfg23");
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h70, 32'h0, "R8 undef read");
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h01, 32'h0, "R8 unaligned read");
    rd(8'h00, 32'h0000_0005, "R8 lock unchanged");
    rd(8'h04, 32'h0000_0003, "R8 owner unchanged");
    // R6 owner released: lock no longer applies
    wr(8'h04, 32'h0);
    wr(8'h10, 32'h0000_1D00);
    rd(8'h10, 32'h0000_1D00, "R6 cfg0 released");
    // R9 outputs
    check("R9 mode0", 32'(pad_mode_o[2:0]), 32'h7);
    check("R9 dirbuf0", 32'(pad_dirbuf_o[1:0]), 32'h1);
    check("R9 mode2", 32'(pad_mode_o[8:6]), 32'h3);
    check("R9 mode23", 32'(pad_mode_o[71:69]), 32'h7);
    check("R9 nmi", 32'(nmi_en_o), 32'h7);
    check("R9 swown", 32'(swown_o), 32'h1);
    check("R9 tx", 32'(pad_tx_o), 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule